// File: doc/BRIEF.md
# Symmetric Toeplitz Receive Hash Engine

This block turns a parsed packet's field vector into a 32-bit receive-side-scaling hash. The upstream parser hands over a fixed array of 16-bit extraction words together with a context number. Each context owns an input-set mask, a symmetry table, a mode bit and a 320-bit Toeplitz key, all loaded through a single-beat configuration write port. The words the mask selects are fed into a Toeplitz hash. In symmetric mode, each selected word is first XORed with the partner word named by its symmetry entry. Programming source and destination address and port words as each other's partners makes the hash identical for both directions of a flow.

On acceptance the engine copies the field vector and the context's tables into working registers. It then steps through the word positions one per cycle. A small state machine drives this with three states. ST_IDLE accepts a vector and moves to ST_RUN (transition "accept"). ST_RUN moves to ST_DONE after the last position (transition "last_word"). ST_DONE presents the result for one cycle and returns to ST_IDLE (transition "release").

Top module: `sym_rss_hash`

## Requirements
- R1: After reset, in_ready is 1, hash_valid is 0 and hash_out is 0. Every context starts with an empty mask, standard mode, no valid symmetry entry and an all-zero key, so any vector hashed in a context that has not been configured gives 0.
- R2: Word i of the field vector is in_fv[16*i+15:16*i]. Only the words whose mask bit is set enter the hash. They enter in ascending index order, each most-significant bit first. Unselected words have no effect and do not advance the key.
- R3: Key word k (k = 0..19) occupies key bits 319-16k down to 304-16k, so key word 0 holds the most significant bits. For each input bit that is 1, the top 32 key bits are XORed into the result. After every input bit the key shifts left by one, with zeros shifted in.
- R4: In symmetric mode, a selected word i whose symmetry entry is valid enters the hash as word i XOR word p, where p is the entry's partner index. With source and destination words paired both ways, swapping them leaves the hash unchanged.
- R5: A symmetry entry written with its valid bit clear leaves its word unmodified, even in symmetric mode. An entry written with a partner index of 48 or more is stored as invalid.
- R6: In standard mode the symmetry table has no effect.
- R7: All tables are held separately for each context. hash_ctx carries the context of the vector that produced the result.
- R8: in_ready falls in the cycle after a vector is accepted and stays low until the result has been shown. hash_valid is high for exactly one cycle, 48 clock edges after the accepting edge.
- R9: A configuration write to a context that is being hashed does not change the result in flight. It applies from the next accepted vector.
- R10: Configuration encoding. cfg_tbl 0 writes mask bit cfg_idx from cfg_data[0]. cfg_tbl 1 writes symmetry entry cfg_idx, with the valid bit in cfg_data[15] and the partner index in cfg_data[5:0]. cfg_tbl 2 writes the mode from cfg_data[0] (1 selects symmetric). cfg_tbl 3 writes key word cfg_idx with cfg_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Field vector offered |
| in_ready | output | 1 | Engine can accept a vector |
| in_ctx | input | 2 | Context of the offered vector |
| in_fv | input | 768 | 48 field words of 16 bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tbl | input | 2 | Table selected for the write |
| cfg_ctx | input | 2 | Context written |
| cfg_idx | input | 6 | Word position or key word number |
| cfg_data | input | 16 | Write data |
| hash_valid | output | 1 | One-cycle result strobe |
| hash_out | output | 32 | Hash result |
| hash_ctx | output | 2 | Context of the result |

## Verification
The symmetry rules and the configuration snapshot have no ports of their own, so a fault in either one shows only as a wrong hash_out in the single cycle where hash_valid is high. That cycle comes 48 edges after acceptance. A stray partner, a key that was not shifted, or a word that was skipped cannot be told apart until that result appears. Hand-worked key windows therefore pin down the bit order. Swapped-direction packet pairs expose a broken pairing, and writes made while a hash is running expose a leak from the live tables into the working copy.

// File: rtl/sym_rss_pkg.sv
package sym_rss_pkg;
    typedef enum logic [1:0] {
        TBL_INSET = 2'd0,
        TBL_SYMM  = 2'd1,
        TBL_MODE  = 2'd2,
        TBL_KEY   = 2'd3
    } cfg_tbl_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } hash_state_e;
endpackage

// File: rtl/sym_rss_cfg_store.sv
module sym_rss_cfg_store #(
    parameter int NUM_WORDS = 48,
    parameter int WORD_W    = 16,
    parameter int NUM_CTX   = 4,
    parameter int KEY_BITS  = 320,
    localparam int CTX_W     = $clog2(NUM_CTX),
    localparam int IDX_W     = $clog2(NUM_WORDS),
    localparam int KEY_WORDS = KEY_BITS / WORD_W,
    localparam int KW_W      = $clog2(KEY_WORDS),
    localparam int CFG_IDX_W = (IDX_W > KW_W) ? IDX_W : KW_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [1:0]                 tbl,
    input  logic [CTX_W-1:0]           wctx,
    input  logic [CFG_IDX_W-1:0]       widx,
    input  logic [WORD_W-1:0]          wdata,
    input  logic [CTX_W-1:0]           rd_ctx,
    output logic [NUM_WORDS-1:0]       rd_mask,
    output logic                       rd_symm,
    output logic [NUM_WORDS-1:0]       rd_sym_vld,
    output logic [NUM_WORDS*IDX_W-1:0] rd_sym_idx,
    output logic [KEY_BITS-1:0]        rd_key
);
    import sym_rss_pkg::*;

    logic [NUM_WORDS-1:0] mask_q    [NUM_CTX];
    logic [NUM_CTX-1:0]   mode_q;
    logic [NUM_WORDS-1:0] sym_vld_q [NUM_CTX];
    logic [IDX_W-1:0]     sym_idx_q [NUM_CTX][NUM_WORDS];
    logic [KEY_BITS-1:0]  key_q     [NUM_CTX];

    logic             ctx_ok;
    logic             word_ok;
    logic             key_ok;
    logic [IDX_W-1:0] wpos;
    logic             partner_ok;

    always_comb begin
        ctx_ok     = int'(wctx) < NUM_CTX;
        word_ok    = int'(widx) < NUM_WORDS;
        key_ok     = int'(widx) < KEY_WORDS;
        wpos       = widx[IDX_W-1:0];
        partner_ok = int'(wdata[IDX_W-1:0]) < NUM_WORDS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            for (int c = 0; c < NUM_CTX; c++) begin
                mask_q[c]    <= '0;
                sym_vld_q[c] <= '0;
                key_q[c]     <= '0;
                for (int i = 0; i < NUM_WORDS; i++) begin
                    sym_idx_q[c][i] <= '0;
                end
            end
        end else if (we && ctx_ok) begin
            unique case (cfg_tbl_e'(tbl))
                TBL_INSET: if (word_ok) mask_q[wctx][wpos] <= wdata[0];
                TBL_SYMM: if (word_ok) begin
                    sym_vld_q[wctx][wpos] <= wdata[WORD_W-1] && partner_ok;
                    sym_idx_q[wctx][wpos] <= wdata[IDX_W-1:0];
                end
                TBL_MODE: mode_q[wctx] <= wdata[0];
                TBL_KEY: if (key_ok)
                    key_q[wctx][KEY_BITS-1-int'(widx)*WORD_W -: WORD_W] <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_mask    = mask_q[rd_ctx];
        rd_symm    = mode_q[rd_ctx];
        rd_sym_vld = sym_vld_q[rd_ctx];
        rd_key     = key_q[rd_ctx];
    end

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_rd_sym
        assign rd_sym_idx[i*IDX_W +: IDX_W] = sym_idx_q[rd_ctx][i];

        // R5
        sym_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_sym_vld[i] |-> (int'(rd_sym_idx[i*IDX_W +: IDX_W]) < NUM_WORDS));
    end
endmodule

// File: rtl/sym_rss_word_mixer.sv
module sym_rss_word_mixer #(
    parameter int NUM_WORDS = 48,
    parameter int WORD_W    = 16,
    localparam int IDX_W    = $clog2(NUM_WORDS)
) (
    input  logic [NUM_WORDS*WORD_W-1:0] fv,
    input  logic [NUM_WORDS-1:0]        mask,
    input  logic                        symm,
    input  logic [NUM_WORDS-1:0]        sym_vld,
    input  logic [NUM_WORDS*IDX_W-1:0]  sym_idx,
    input  logic [IDX_W-1:0]            pos,
    output logic                        word_sel,
    output logic [WORD_W-1:0]           word_out
);
    logic [WORD_W-1:0] fv_w  [NUM_WORDS];
    logic [IDX_W-1:0]  map_w [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_split
        assign fv_w[i]  = fv[i*WORD_W +: WORD_W];
        assign map_w[i] = sym_idx[i*IDX_W +: IDX_W];
    end

    logic [WORD_W-1:0] own_w;
    logic [WORD_W-1:0] mate_w;
    logic              pair_on;

    always_comb begin
        own_w    = fv_w[pos];
        mate_w   = fv_w[map_w[pos]];
        pair_on  = symm && sym_vld[pos];
        word_sel = mask[pos];
        word_out = pair_on ? (own_w ^ mate_w) : own_w;
    end
endmodule

// File: rtl/sym_rss_toeplitz_step.sv
module sym_rss_toeplitz_step #(
    parameter int WORD_W   = 16,
    parameter int KEY_BITS = 320,
    parameter int HASH_W   = 32
) (
    input  logic [KEY_BITS-1:0] key_in,
    input  logic [HASH_W-1:0]   acc_in,
    input  logic [WORD_W-1:0]   word,
    output logic [KEY_BITS-1:0] key_out,
    output logic [HASH_W-1:0]   acc_out
);
    logic [KEY_BITS-1:0] k;
    logic [HASH_W-1:0]   a;

    always_comb begin
        k = key_in;
        a = acc_in;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (word[b]) a = a ^ k[KEY_BITS-1 -: HASH_W];
            k = {k[KEY_BITS-2:0], 1'b0};
        end
        key_out = k;
        acc_out = a;
    end
endmodule

// File: rtl/sym_rss_hash.sv
module sym_rss_hash #(
    parameter int NUM_WORDS = 48,
    parameter int WORD_W    = 16,
    parameter int NUM_CTX   = 4,
    parameter int KEY_BITS  = 320,
    parameter int HASH_W    = 32,
    localparam int CTX_W     = $clog2(NUM_CTX),
    localparam int IDX_W     = $clog2(NUM_WORDS),
    localparam int KEY_WORDS = KEY_BITS / WORD_W,
    localparam int KW_W      = $clog2(KEY_WORDS),
    localparam int CFG_IDX_W = (IDX_W > KW_W) ? IDX_W : KW_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [CTX_W-1:0]            in_ctx,
    input  logic [NUM_WORDS*WORD_W-1:0] in_fv,
    input  logic                        cfg_we,
    input  logic [1:0]                  cfg_tbl,
    input  logic [CTX_W-1:0]            cfg_ctx,
    input  logic [CFG_IDX_W-1:0]        cfg_idx,
    input  logic [WORD_W-1:0]           cfg_data,
    output logic                        hash_valid,
    output logic [HASH_W-1:0]           hash_out,
    output logic [CTX_W-1:0]            hash_ctx
);
    import sym_rss_pkg::*;

    hash_state_e state_q, state_d;

    logic [NUM_WORDS-1:0]       live_mask;
    logic                       live_symm;
    logic [NUM_WORDS-1:0]       live_vld;
    logic [NUM_WORDS*IDX_W-1:0] live_idx;
    logic [KEY_BITS-1:0]        live_key;

    logic [NUM_WORDS*WORD_W-1:0] fv_q;
    logic [NUM_WORDS-1:0]        mask_q;
    logic                        symm_q;
    logic [NUM_WORDS-1:0]        vld_q;
    logic [NUM_WORDS*IDX_W-1:0]  idx_q;
    logic [KEY_BITS-1:0]         key_q;
    logic [HASH_W-1:0]           acc_q;
    logic [CTX_W-1:0]            ctx_q;
    logic [IDX_W-1:0]            pos_q;

    logic                word_sel;
    logic [WORD_W-1:0]   word_mix;
    logic [KEY_BITS-1:0] key_nxt;
    logic [HASH_W-1:0]   acc_nxt;
    logic                accept;
    logic                last_pos;

    sym_rss_cfg_store #(
        .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W),
        .NUM_CTX(NUM_CTX), .KEY_BITS(KEY_BITS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(cfg_we), .tbl(cfg_tbl), .wctx(cfg_ctx), .widx(cfg_idx), .wdata(cfg_data),
        .rd_ctx(in_ctx),
        .rd_mask(live_mask), .rd_symm(live_symm), .rd_sym_vld(live_vld),
        .rd_sym_idx(live_idx), .rd_key(live_key)
    );

    sym_rss_word_mixer #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_mix (
        .fv(fv_q), .mask(mask_q), .symm(symm_q), .sym_vld(vld_q), .sym_idx(idx_q),
        .pos(pos_q), .word_sel(word_sel), .word_out(word_mix)
    );

    sym_rss_toeplitz_step #(.WORD_W(WORD_W), .KEY_BITS(KEY_BITS), .HASH_W(HASH_W)) u_step (
        .key_in(key_q), .acc_in(acc_q), .word(word_mix),
        .key_out(key_nxt), .acc_out(acc_nxt)
    );

    always_comb begin
        accept   = (state_q == ST_IDLE) && in_valid;
        last_pos = int'(pos_q) == NUM_WORDS - 1;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_RUN;    // accept
            ST_RUN:  if (last_pos) state_d = ST_DONE;   // last_word
            ST_DONE: state_d = ST_IDLE;                 // release
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // working copy and iteration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fv_q   <= '0;
            mask_q <= '0;
            symm_q <= 1'b0;
            vld_q  <= '0;
            idx_q  <= '0;
            key_q  <= '0;
            acc_q  <= '0;
            ctx_q  <= '0;
            pos_q  <= '0;
        end else if (accept) begin
            fv_q   <= in_fv;
            mask_q <= live_mask;
            symm_q <= live_symm;
            vld_q  <= live_vld;
            idx_q  <= live_idx;
            key_q  <= live_key;
            acc_q  <= '0;
            ctx_q  <= in_ctx;
            pos_q  <= '0;
        end else if (state_q == ST_RUN) begin
            pos_q <= pos_q + 1'b1;
            if (word_sel) begin
                key_q <= key_nxt;
                acc_q <= acc_nxt;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready   = state_q == ST_IDLE;
        hash_valid = state_q == ST_DONE;
        hash_out   = acc_q;
        hash_ctx   = ctx_q;
    end

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hash_valid |=> !hash_valid);

    // R8
    result_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hash_valid) |-> ($past(state_q) == ST_RUN && $past(last_pos)));

    // R7
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(hash_ctx));
endmodule

// File: tb/tb_sym_rss_hash.sv
`timescale 1ns/1ps
module tb_sym_rss_hash;
    localparam int NW = 48;
    localparam int KB = 320;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_ctx = '0;
    logic [NW*16-1:0] in_fv = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_tbl = '0;
    logic [1:0]    cfg_ctx = '0;
    logic [5:0]    cfg_idx = '0;
    logic [15:0]   cfg_data = '0;
    logic          hash_valid;
    logic [31:0]   hash_out;
    logic [1:0]    hash_ctx;

    always #2.5 clk = ~clk;

    sym_rss_hash dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_ctx(in_ctx), .in_fv(in_fv), .cfg_we(cfg_we), .cfg_tbl(cfg_tbl),
        .cfg_ctx(cfg_ctx), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .hash_valid(hash_valid), .hash_out(hash_out), .hash_ctx(hash_ctx)
    );

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;
    logic [31:0] last_hash = '0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic [31:0] hash;
        int          ctx;
        longint      when;
        string       req;
    } exp_t;
    exp_t sb_q[$];
    exp_t got;

    // configuration mirror
    bit [NW-1:0] mask_m [4];
    bit          mode_m [4];
    bit          sv_m   [4][NW];
    int          si_m   [4][NW];
    bit [KB-1:0] key_m  [4];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [NW*16-1:0] fv, input int c);
        bit [KB-1:0] k = key_m[c];
        logic [31:0] a = '0;
        logic [15:0] w;
        for (int i = 0; i < NW; i++) begin
            if (mask_m[c][i]) begin
                w = fv[i*16 +: 16];
                if (mode_m[c] && sv_m[c][i]) w = w ^ fv[si_m[c][i]*16 +: 16];
                for (int b = 15; b >= 0; b--) begin
                    if (w[b]) a = a ^ k[KB-1 -: 32];
                    k = k << 1;
                end
            end
        end
        return a;
    endfunction

    task automatic cfg_wr(input int tbl, input int c, input int idx, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_tbl = tbl[1:0]; cfg_ctx = c[1:0];
        cfg_idx = idx[5:0]; cfg_data = d;
        case (tbl)
            0: mask_m[c][idx] = d[0];
            1: begin
                sv_m[c][idx] = d[15] && (int'(d[5:0]) < NW);
                si_m[c][idx] = int'(d[5:0]);
            end
            2: mode_m[c] = d[0];
            default: key_m[c][KB-1-idx*16 -: 16] = d;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input int c, input logic [NW*16-1:0] fv, input logic [31:0] exp, input string req);
        exp_t e;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_ctx = c[1:0]; in_fv = fv;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        e.hash = exp; e.ctx = c; e.when = cyc + NW; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && hash_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R8 unexpected result", 64'(hash_out), 64'h0);
            end else begin
                got = sb_q.pop_front();
                chk(hash_out == got.hash, got.req, 64'(hash_out), 64'(got.hash));
                chk(int'(hash_ctx) == got.ctx, "R7 hash_ctx", 64'(hash_ctx), 64'(got.ctx));
                chk(cyc == got.when, "R8 result cycle", 64'(cyc), 64'(got.when));
                last_hash = hash_out;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 64'(cyc), 64'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [NW*16-1:0] rnd_fv();
        logic [NW*16-1:0] v;
        for (int i = 0; i < NW; i++) v[i*16 +: 16] = 16'($urandom);
        return v;
    endfunction

    initial begin
        logic [NW*16-1:0] fa, fb, fc;
        logic [31:0] h_a;
        for (int c = 0; c < 4; c++) begin
            mask_m[c] = '0; mode_m[c] = 1'b0; key_m[c] = '0;
            for (int i = 0; i < NW; i++) begin sv_m[c][i] = 1'b0; si_m[c][i] = 0; end
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'h1);
        chk(hash_valid == 1'b0, "R1 hash_valid after reset", 64'(hash_valid), 64'h0);
        chk(hash_out == 32'h0, "R1 hash_out after reset", 64'(hash_out), 64'h0);
        send(2, rnd_fv(), 32'h0, "R1 unconfigured context");
        drain();

        // R3 / R10 hand-worked windows on context 3
        cfg_wr(3, 3, 0, 16'hABCD);
        cfg_wr(3, 3, 1, 16'h1234);
        cfg_wr(0, 3, 0, 16'h0001);
        fa = rnd_fv(); fa[15:0] = 16'h8000;
        send(3, fa, 32'hABCD1234, "R3 first key window");
        fa[15:0] = 16'h0001;
        send(3, fa, 32'h891A0000, "R3 window after 15 shifts");
        drain();
        // R2 unselected word does not shift key
        cfg_wr(0, 3, 2, 16'h0001);
        fa = rnd_fv(); fa[15:0] = 16'h0000; fa[31:16] = 16'hFFFF; fa[47:32] = 16'h8000;
        send(3, fa, 32'h12340000, "R2 order and skip");
        drain();

        // R2 / R3 full key, context 0, sparse mask
        for (int k = 0; k < 20; k++) cfg_wr(3, 0, k, 16'($urandom));
        cfg_wr(0, 0, 0, 16'h1); cfg_wr(0, 0, 1, 16'h1);
        cfg_wr(0, 0, 5, 16'h1); cfg_wr(0, 0, 47, 16'h1);
        for (int n = 0; n < 3; n++) begin
            fa = rnd_fv();
            send(0, fa, model(fa, 0), "R2 sparse mask");
        end
        drain();

        // R4 symmetric context 1: words 0..3 addresses, 4..5 ports
        for (int k = 0; k < 20; k++) cfg_wr(3, 1, k, 16'($urandom));
        for (int i = 0; i < 6; i++) cfg_wr(0, 1, i, 16'h1);
        cfg_wr(1, 1, 0, 16'h8002); cfg_wr(1, 1, 2, 16'h8000);
        cfg_wr(1, 1, 1, 16'h8003); cfg_wr(1, 1, 3, 16'h8001);
        cfg_wr(1, 1, 4, 16'h8005); cfg_wr(1, 1, 5, 16'h8004);
        cfg_wr(2, 1, 0, 16'h1);
        fa = rnd_fv();
        fb = fa;
        fb[31:0]   = fa[63:32];
        fb[63:32]  = fa[31:0];
        fb[79:64]  = fa[95:80];
        fb[95:80]  = fa[79:64];
        send(1, fa, model(fa, 1), "R4 forward direction");
        drain();
        h_a = last_hash;
        send(1, fb, model(fb, 1), "R4 reverse direction");
        drain();
        chk(last_hash == h_a, "R4 swapped flow same hash", 64'(last_hash), 64'(h_a));

        // R6 standard context 0 with the same pairing loaded
        for (int i = 0; i < 6; i++) cfg_wr(0, 0, i, 16'h1);
        cfg_wr(1, 0, 0, 16'h8002); cfg_wr(1, 0, 2, 16'h8000);
        cfg_wr(1, 0, 4, 16'h8005); cfg_wr(1, 0, 5, 16'h8004);
        send(0, fa, model(fa, 0), "R6 standard ignores pairs fwd");
        send(0, fb, model(fb, 0), "R6 standard ignores pairs rev");
        drain();

        // R5 invalid entry and out-of-range partner
        cfg_wr(0, 1, 6, 16'h1); cfg_wr(0, 1, 8, 16'h1);
        cfg_wr(1, 1, 6, 16'h0007);
        cfg_wr(1, 1, 8, 16'h8032);
        fc = rnd_fv();
        send(1, fc, model(fc, 1), "R5 invalid entries pass word");
        drain();

        // R9 write during computation
        fa = '0; fa[15:0] = 16'h8000; fa[47:32] = 16'h8000;
        send(3, fa, 32'hABCD1234 ^ 32'h12340000, "R9 in-flight result");
        cfg_wr(3, 3, 0, 16'h0000);
        cfg_wr(0, 3, 2, 16'h0000);
        cfg_wr(2, 3, 0, 16'h0001);
        drain();
        send(3, fa, 32'h00001234, "R9 new config applied");
        drain();

        // R10 mode write back to standard on context 1
        cfg_wr(2, 1, 0, 16'h0);
        send(1, fa | fc, model(fa | fc, 1), "R10 mode cleared");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule